// File: doc/BRIEF.md
# GPIO Unit with Interrupt Conditioning

This block is a general-purpose I/O controller. Software reaches it through a narrow register bus that is half the width of its registers. Each register therefore appears as a pair of half-word locations. The unit drives two output banks. The first bank belongs to bidirectional pins that can also act as interrupt sources. The second bank is output-only.

Each bidirectional pin has its own conditioning settings:
- a direction bit;
- a trigger type, edge or level;
- a sense bit, which gives the level polarity or the edge direction;
- a hold/through choice, which decides whether a detected condition latches or follows the input.

An enable mask gates the status bits into a single interrupt line. Pin inputs are assumed to be synchronous to the block clock.

In a typical use, software sets a pin as an input and chooses its trigger, sense and hold mode. It then clears any stale status and enables the pin. When the interrupt line rises, software reads the status and writes the same value back to clear the latched bits.

Top module: `gpio_irq_unit`

## Requirements
- R1: While reset is asserted, every register reads as zero and `pin_oe`, `pin_out`, `ext_out` and `irq` are all zero.
- R2: The bus address is `reg_code*2 + half`. The register codes are: direction 0, pin data 1, extra output 2, status 3, enable 4, trigger type 5, sense 6, hold 7. Half 0 holds bits 15:0 and half 1 holds bits 31:16. Writing one half leaves the other half of the same register unchanged.
- R3: `pin_oe` equals the direction register (1 = output) and `pin_out` equals the pin data latch. A pin whose direction bit is 1 never sets a through-mode status bit.
- R4: Reading the pin data register returns, per bit, the data latch where direction is 1, and the pin value sampled at the previous clock edge where direction is 0.
- R5: The extra output register (output bits 32 to 63) drives `ext_out` and reads back unchanged.
- R6: With trigger type 0 (level), an input pin's condition is true while the pin equals its sense bit (1 = active-high, 0 = active-low).
- R7: With trigger type 1 (edge), the condition is true for one cycle on a rising edge when sense is 1 and on a falling edge when sense is 0. An edge is found by comparing the pin with its previous sample.
- R8: With hold set to 1, a status bit stays set until a 1 is written to it at the status address. If a condition occurs in the same cycle as the clear, the condition wins.
- R9: With hold set to 0, a status bit is the condition evaluated at the previous clock edge. Writes to the status address have no effect on it.
- R10: `irq` is high exactly when some status bit and its enable bit are both 1. Status updates at the clock edge that samples the input, so `irq` follows one edge after the input changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Half-word register address |
| bus_wr | input | 1 | Write strobe for the addressed half-word |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the addressed half-word (combinational) |
| pin_in | input | 32 | Sampled value of the bidirectional pins |
| pin_out | output | 32 | Output latch for the bidirectional pins |
| pin_oe | output | 32 | Per-pin output enable |
| ext_out | output | 32 | Output-only bank, bits 32 to 63 |
| irq | output | 1 | Combined enabled interrupt |

## Verification
The assertions check several properties on every cycle:
- a latched status bit never drops without a matching clear;
- an output-mode or quiet edge-mode pin never raises through-mode status;
- a half-word write disturbs neither the other half nor the output-enable mapping;
- an all-zero enable keeps `irq` low.

Other behaviour needs the bench's scenarios: the exact polarity of level and edge detection, the read-back mix of latch and sampled pin, set-over-clear priority, and the irq timing after an input change. The behavioural model checks these against every clock, under both directed and random traffic.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

   localparam int NUM_REGS = 8;

   typedef enum logic [2:0] {
      REG_DIR  = 3'd0,
      REG_PIN  = 3'd1,
      REG_EXT  = 3'd2,
      REG_STAT = 3'd3,
      REG_EN   = 3'd4,
      REG_TYPE = 3'd5,
      REG_LVL  = 3'd6,
      REG_HOLD = 3'd7
   } gpio_reg_e;

endpackage

// File: rtl/gpio_wr_decode.sv
module gpio_wr_decode #(
   parameter int ADDR_W = 4,
   localparam int N_STB = 2 ** ADDR_W
) (
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   output logic [N_STB-1:0]  strobe
);

   always_comb begin
      strobe = '0;
      if (bus_wr) strobe[bus_addr] = 1'b1;
   end

endmodule

// File: rtl/gpio_split_reg.sv
module gpio_split_reg #(
   parameter int W  = 32,
   parameter int HW = 16,
   localparam int NH = W / HW
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [NH-1:0] wr_half,
   input  logic [HW-1:0] wdata,
   output logic [W-1:0]  q
);

   for (genvar h = 0; h < NH; h++) begin : g_half
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          q[h*HW +: HW] <= '0;
         else if (wr_half[h]) q[h*HW +: HW] <= wdata;
      end
   end

endmodule

// File: rtl/gpio_event_cond.sv
module gpio_event_cond #(
   parameter int N = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] pin_in,
   input  logic [N-1:0] dir,
   input  logic [N-1:0] typ,
   input  logic [N-1:0] lvl,
   output logic [N-1:0] pin_q,
   output logic [N-1:0] cond
);

   for (genvar i = 0; i < N; i++) begin : g_pin
      logic edge_hit;
      logic level_hit;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) pin_q[i] <= 1'b0;
         else        pin_q[i] <= pin_in[i];
      end

      assign edge_hit  = lvl[i] ? (pin_in[i] & ~pin_q[i]) : (~pin_in[i] & pin_q[i]);
      assign level_hit = (pin_in[i] == lvl[i]);
      assign cond[i]   = ~dir[i] & (typ[i] ? edge_hit : level_hit);
   end

endmodule

// File: rtl/gpio_status.sv
module gpio_status #(
   parameter int N = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] cond,
   input  logic [N-1:0] hold,
   input  logic [N-1:0] clr,
   output logic [N-1:0] stat
);

   for (genvar i = 0; i < N; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      stat[i] <= 1'b0;
         else if (hold[i]) stat[i] <= (stat[i] & ~clr[i]) | cond[i];
         else             stat[i] <= cond[i];
      end
   end

endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit
   import gpio_irq_pkg::*;
#(
   parameter int REG_W = 32,
   parameter int HW_W  = 16,
   localparam int NH     = REG_W / HW_W,
   localparam int HALF_B = (NH > 1) ? $clog2(NH) : 1,
   localparam int ADDR_W = 3 + HALF_B
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [HW_W-1:0]   bus_wdata,
   output logic [HW_W-1:0]   bus_rdata,
   input  logic [REG_W-1:0]  pin_in,
   output logic [REG_W-1:0]  pin_out,
   output logic [REG_W-1:0]  pin_oe,
   output logic [REG_W-1:0]  ext_out,
   output logic              irq
);

   if (REG_W % HW_W != 0) begin : g_bad_split
      $error("REG_W must be a multiple of HW_W");
   end
   if (NH < 2 || (NH & (NH - 1)) != 0) begin : g_bad_halves
      $error("REG_W / HW_W must be a power of two of at least 2");
   end

   localparam int N_STB = NUM_REGS * NH;

   logic [N_STB-1:0]                wr_stb;
   logic [NUM_REGS-1:0][REG_W-1:0]  reg_q;
   logic [REG_W-1:0] dir_q, pd_q, ext_q, en_q, typ_q, lvl_q, hold_q;
   logic [REG_W-1:0] stat_q, pin_q, cond, clr_mask;
   logic [2:0]        reg_sel;
   logic [HALF_B-1:0] half_sel;
   logic [REG_W-1:0]  rd_word;

   gpio_wr_decode #(.ADDR_W(ADDR_W)) u_dec (
      .bus_wr   (bus_wr),
      .bus_addr (bus_addr),
      .strobe   (wr_stb)
   );

   // Plain configuration registers; the status slot is built separately.
   for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
      if (r != int'(REG_STAT)) begin : g_cfg
         gpio_split_reg #(.W(REG_W), .HW(HW_W)) u_reg (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_half (wr_stb[r*NH +: NH]),
            .wdata   (bus_wdata),
            .q       (reg_q[r])
         );
      end
   end

   // Write-one-to-clear mask, one slice per half-word.
   for (genvar h = 0; h < NH; h++) begin : g_clr
      assign clr_mask[h*HW_W +: HW_W] =
         wr_stb[int'(REG_STAT)*NH + h] ? bus_wdata : '0;
   end

   assign dir_q  = reg_q[REG_DIR];
   assign pd_q   = reg_q[REG_PIN];
   assign ext_q  = reg_q[REG_EXT];
   assign en_q   = reg_q[REG_EN];
   assign typ_q  = reg_q[REG_TYPE];
   assign lvl_q  = reg_q[REG_LVL];
   assign hold_q = reg_q[REG_HOLD];

   gpio_event_cond #(.N(REG_W)) u_cond (
      .clk    (clk),
      .rst_n  (rst_n),
      .pin_in (pin_in),
      .dir    (dir_q),
      .typ    (typ_q),
      .lvl    (lvl_q),
      .pin_q  (pin_q),
      .cond   (cond)
   );

   gpio_status #(.N(REG_W)) u_stat (
      .clk   (clk),
      .rst_n (rst_n),
      .cond  (cond),
      .hold  (hold_q),
      .clr   (clr_mask),
      .stat  (stat_q)
   );

   assign reg_q[REG_STAT] = stat_q;

   assign reg_sel  = bus_addr[ADDR_W-1 -: 3];
   assign half_sel = bus_addr[HALF_B-1:0];

   always_comb begin
      rd_word = reg_q[reg_sel];
      if (reg_sel == REG_PIN) rd_word = (pd_q & dir_q) | (pin_q & ~dir_q);
      bus_rdata = rd_word[half_sel*HW_W +: HW_W];
   end

   assign pin_out = pd_q;
   assign pin_oe  = dir_q;
   assign ext_out = ext_q;
   assign irq     = |(stat_q & en_q);

endmodule

// File: rtl/gpio_irq_unit_chk.sv
module gpio_irq_unit_chk #(
   parameter int REG_W = 32,
   parameter int HW_W  = 16,
   localparam int NH     = REG_W / HW_W,
   localparam int HALF_B = (NH > 1) ? $clog2(NH) : 1,
   localparam int ADDR_W = 3 + HALF_B
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_wr,
   input logic [HW_W-1:0]   bus_wdata,
   input logic [REG_W-1:0]  pin_in,
   input logic [REG_W-1:0]  pin_oe,
   input logic              irq,
   input logic [REG_W-1:0]  dir_q,
   input logic [REG_W-1:0]  en_q,
   input logic [REG_W-1:0]  typ_q,
   input logic [REG_W-1:0]  hold_q,
   input logic [REG_W-1:0]  stat_q,
   input logic [REG_W-1:0]  pin_q,
   input logic [REG_W-1:0]  clr_mask
);

   localparam logic [ADDR_W-1:0] DIR_LO = '0;

   // R2
   half_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == DIR_LO)
      |=> dir_q[REG_W-1:HW_W] == $past(dir_q[REG_W-1:HW_W]));

   // R3
   oe_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == DIR_LO) |=> pin_oe[HW_W-1:0] == $past(bus_wdata));

   // R3
   out_no_stat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((stat_q & $past(dir_q & ~hold_q)) == '0));

   // R8
   hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((~stat_q & $past(stat_q & hold_q & ~clr_mask)) == '0));

   // R7
   quiet_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((stat_q & $past(typ_q & ~hold_q & ~(pin_in ^ pin_q))) == '0));

   // R10
   masked_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q == '0) |-> !irq);

endmodule

bind gpio_irq_unit gpio_irq_unit_chk #(.REG_W(REG_W), .HW_W(HW_W)) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_addr  (bus_addr),
   .bus_wr    (bus_wr),
   .bus_wdata (bus_wdata),
   .pin_in    (pin_in),
   .pin_oe    (pin_oe),
   .irq       (irq),
   .dir_q     (dir_q),
   .en_q      (en_q),
   .typ_q     (typ_q),
   .hold_q    (hold_q),
   .stat_q    (stat_q),
   .pin_q     (pin_q),
   .clr_mask  (clr_mask)
);

// File: tb/test_gpio_irq_unit.sv
module test_gpio_irq_unit;

   localparam int CLK_PERIOD = 10;

   logic        clk;
   logic        rst_n;
   logic [3:0]  bus_addr;
   logic        bus_wr;
   logic [15:0] bus_wdata;
   logic [15:0] bus_rdata;
   logic [31:0] pin_in;
   logic [31:0] pin_out;
   logic [31:0] pin_oe;
   logic [31:0] ext_out;
   logic        irq;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 0;

   gpio_irq_unit #(.REG_W(32), .HW_W(16)) i_gpio_irq_unit (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_wr    (bus_wr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .pin_in    (pin_in),
      .pin_out   (pin_out),
      .pin_oe    (pin_oe),
      .ext_out   (ext_out),
      .irq       (irq)
   );

   initial clk = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   // Behavioural reference model
   logic [31:0] m_dir, m_pd, m_ext, m_stat, m_en, m_typ, m_lvl, m_hold, m_pinq;
   logic [31:0] m_clr, m_nst;
   bit          m_c;

   function automatic logic [31:0] put(logic [31:0] old, logic h, logic [15:0] d);
      return h ? {d, old[15:0]} : {old[31:16], d};
   endfunction

   function automatic logic [31:0] m_word(int r);
      case (r)
         0: return m_dir;
         1: return (m_pd & m_dir) | (m_pinq & ~m_dir);
         2: return m_ext;
         3: return m_stat;
         4: return m_en;
         5: return m_typ;
         6: return m_lvl;
         default: return m_hold;
      endcase
   endfunction

   function automatic string rtag(int r);
      case (r)
         1: return "R4";
         2: return "R5";
         3: return "R8";
         default: return "R2";
      endcase
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_dir = 0; m_pd = 0; m_ext = 0; m_stat = 0; m_en = 0;
         m_typ = 0; m_lvl = 0; m_hold = 0; m_pinq = 0;
      end else begin
         m_clr = 0;
         if (bus_wr && bus_addr[3:1] == 3'd3)
            m_clr = bus_addr[0] ? {bus_wdata, 16'h0} : {16'h0, bus_wdata};
         for (int i = 0; i < 32; i++) begin
            if (m_dir[i]) m_c = 0;
            else if (m_typ[i])
               m_c = m_lvl[i] ? (pin_in[i] && !m_pinq[i]) : (!pin_in[i] && m_pinq[i]);
            else m_c = (pin_in[i] == m_lvl[i]);
            m_nst[i] = m_hold[i] ? ((m_stat[i] && !m_clr[i]) || m_c) : m_c;
         end
         if (bus_wr) begin
            case (bus_addr[3:1])
               3'd0: m_dir  = put(m_dir,  bus_addr[0], bus_wdata);
               3'd1: m_pd   = put(m_pd,   bus_addr[0], bus_wdata);
               3'd2: m_ext  = put(m_ext,  bus_addr[0], bus_wdata);
               3'd4: m_en   = put(m_en,   bus_addr[0], bus_wdata);
               3'd5: m_typ  = put(m_typ,  bus_addr[0], bus_wdata);
               3'd6: m_lvl  = put(m_lvl,  bus_addr[0], bus_wdata);
               3'd7: m_hold = put(m_hold, bus_addr[0], bus_wdata);
               default: ;
            endcase
         end
         m_stat = m_nst;
         m_pinq = pin_in;
      end
   end

   task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
      end
   endtask

   // Per-cycle comparison against the model
   always @(negedge clk) begin
      if (!done) begin
         logic [31:0] w;
         w = m_word(int'(bus_addr[3:1]));
         chk("R10", {31'h0, irq}, {31'h0, |(m_stat & m_en)});
         chk("R3", pin_oe, m_dir);
         chk("R3", pin_out, m_pd);
         chk("R5", ext_out, m_ext);
         chk(rtag(int'(bus_addr[3:1])), {16'h0, bus_rdata},
             {16'h0, bus_addr[0] ? w[31:16] : w[15:0]});
      end
   end

   task automatic step(int n);
      repeat (n) @(negedge clk);
      #1;
   endtask

   task automatic wr16(logic [3:0] a, logic [15:0] d);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      step(1);
      bus_wr = 1'b0;
   endtask

   task automatic rd16(logic [3:0] a, logic [15:0] exp, string tag);
      bus_addr = a;
      @(negedge clk);
      chk(tag, {16'h0, bus_rdata}, {16'h0, exp});
      #1;
   endtask

   initial begin
      #(CLK_PERIOD * 20000);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; bus_addr = 4'd6; bus_wr = 1'b0; bus_wdata = '0; pin_in = '0;
      step(2);
      // R1: everything cleared while in reset
      chk("R1", {16'h0, bus_rdata}, 32'h0);
      chk("R1", {31'h0, irq}, 32'h0);
      chk("R1", pin_oe | pin_out | ext_out, 32'h0);
      rst_n = 1'b1;
      step(1);

      // R2: half-word independence
      wr16(4'd1, 16'hA5A5);
      rd16(4'd0, 16'h0000, "R2");
      rd16(4'd1, 16'hA5A5, "R2");
      wr16(4'd0, 16'h00FF);
      chk("R3", pin_oe, 32'hA5A5_00FF);
      wr16(4'd2, 16'h1234);
      wr16(4'd3, 16'hFFFF);
      chk("R3", pin_out, 32'hFFFF_1234);

      // R4: latch / sampled pin mix
      pin_in = 32'h0F0F_F0F0;
      step(1);
      rd16(4'd2, 16'hF034, "R4");
      rd16(4'd3, 16'hAFAF, "R4");

      // R5: extra output bank
      wr16(4'd4, 16'hBEEF);
      wr16(4'd5, 16'hDEAD);
      chk("R5", ext_out, 32'hDEAD_BEEF);
      rd16(4'd5, 16'hDEAD, "R5");

      // R3: output pins raise no status (pins 0-7 are outputs)
      rd16(4'd6, 16'h0F00, "R3");

      // Interrupt configuration
      wr16(4'd0, 16'h0000);
      wr16(4'd1, 16'h0000);
      pin_in = 32'h0000_0002;
      wr16(4'd10, 16'h001C);
      wr16(4'd12, 16'h0015);
      wr16(4'd14, 16'h000E);
      wr16(4'd8, 16'h001F);
      step(2);
      wr16(4'd6, 16'hFFFF);
      wr16(4'd7, 16'hFFFF);
      step(1);
      rd16(4'd6, 16'hFFE0, "R9");
      chk("R10", {31'h0, irq}, 32'h0);

      // R9: status writes ignored for through bits
      wr16(4'd6, 16'hFFE0);
      rd16(4'd6, 16'hFFE0, "R9");

      // R6: level active-high on pin 0
      pin_in = 32'h0000_0003;
      step(2);
      chk("R6", {31'h0, irq}, 32'h1);
      rd16(4'd6, 16'hFFE1, "R6");
      pin_in = 32'h0000_0002;
      step(2);
      chk("R9", {31'h0, irq}, 32'h0);
      rd16(4'd6, 16'hFFE0, "R9");

      // R7: rising edge on pin 2, held
      pin_in = 32'h0000_0006;
      step(2);
      pin_in = 32'h0000_0002;
      step(2);
      rd16(4'd6, 16'hFFE4, "R7");
      chk("R8", {31'h0, irq}, 32'h1);
      wr16(4'd6, 16'h0004);
      rd16(4'd6, 16'hFFE0, "R8");
      chk("R8", {31'h0, irq}, 32'h0);

      // R7: falling edge on pin 3
      pin_in = 32'h0000_000A;
      step(2);
      rd16(4'd6, 16'hFFE0, "R7");
      pin_in = 32'h0000_0002;
      step(2);
      rd16(4'd6, 16'hFFE8, "R7");
      wr16(4'd6, 16'h0008);

      // R8: active-low hold on pin 1, set beats clear
      pin_in = 32'h0000_0000;
      step(2);
      wr16(4'd6, 16'h0002);
      rd16(4'd6, 16'hFFE2, "R8");
      pin_in = 32'h0000_0002;
      step(2);
      rd16(4'd6, 16'hFFE2, "R8");
      wr16(4'd6, 16'h0002);
      rd16(4'd6, 16'hFFE0, "R8");

      // R10: enable masking
      pin_in = 32'h0000_0003;
      wr16(4'd8, 16'h0000);
      step(2);
      chk("R10", {31'h0, irq}, 32'h0);
      rd16(4'd6, 16'hFFE1, "R10");
      wr16(4'd8, 16'h0001);
      chk("R10", {31'h0, irq}, 32'h1);

      // R6: active-low sense on pin 0 while high
      wr16(4'd12, 16'h0014);
      step(2);
      rd16(4'd6, 16'hFFE0, "R6");

      // R3: pin 0 made an output no longer raises status
      wr16(4'd0, 16'h0001);
      wr16(4'd12, 16'h0015);
      step(2);
      rd16(4'd6, 16'hFFE0, "R3");

      // Random traffic against the model
      for (int k = 0; k < 600; k++) begin
         pin_in = $urandom;
         bus_addr = 4'($urandom);
         bus_wdata = 16'($urandom);
         bus_wr = ($urandom % 3) == 0;
         step(1);
      end
      bus_wr = 1'b0;
      step(2);

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule